// File: doc/BRIEF.md
# Two-Tier Shared Memory Slot Arbiter

This block arbitrates one shared memory port among sixteen processor cores and issues at most one grant per system clock. A free-running slot counter walks through the cores in a fixed rotation. When at least one core is marked primary, the arbiter runs in two tiers. Each primary core owns the slot whose number equals its index, so its access timing repeats exactly every sixteen clocks. Any slot that is not used by its primary owner becomes a spare slot for the secondary group.

The secondary group consists of the enabled cores that are not primary. These cores raise requests on a separate set of sixteen lines. Spare slots go to this group in one of two ways. In table mode, a 32-entry assignment table names the receiving core. A table pointer moves to the next entry only when a spare slot is actually handed out. In scan mode, the arbiter searches outward from the current slot number and grants the closest requesting secondary core.

When no core is marked primary, the block is a plain sixteen-slot round robin, and spare slots stay idle. A core whose enable bit is cleared takes no part in the rotation and receives no grant of either kind. The configuration port writes the masks and the mode together. The table has its own write port. Grants are plain control outputs with no handshake: a grant is a one-cycle pulse, and the core must be ready to use it.

Top module: `hub_slot_arb`

## Requirements
- R1: A synchronous reset clears the grant outputs, sets the slot counter and the table pointer to 0, clears the primary mask and every table valid bit, sets every enable bit, and selects table mode. After reset the block is a plain round robin.
- R2: With the primary mask all zero, slot s (the counter value, which advances by one per clock starting at 0 after reset) is granted to core s only when core s is enabled and its `own_req_i` bit is set. Otherwise the slot is idle, and `sec_req_i` has no effect.
- R3: A core whose enable bit is 0 is never granted, either in its own slot or through the secondary tier.
- R4: In two-tier mode, an enabled primary core that requests in its own slot is always granted that slot, whatever the secondary requests, the table contents or the mode.
- R5: In table mode (mode bit 0), a spare slot goes to the core named by the table entry at the pointer, when that entry is valid and the named core is an eligible secondary requester. The pointer then steps by one, modulo 32.
- R6: In table mode, if the entry at the pointer is invalid, or the core it names is not an eligible requester, the spare slot is idle and the pointer holds.
- R7: In scan mode (mode bit 1), a spare slot at slot s goes to the eligible secondary core at the smallest ring distance from s, distance 0 included. On a tie the forward index (s+d mod 16) wins.
- R8: Only enabled, non-primary cores are eligible in the secondary tier, through `sec_req_i`. In two-tier mode a non-primary core's `own_req_i` does not win its slot.
- R9: A grant decided from the requests seen at clock edge k appears on the outputs after edge k. `grant_o` is one-hot or zero, `grant_idx_o` names the set bit, and a grant only goes to a core that requested at edge k.
- R10: A configuration write at edge k applies to the slot decided at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_req_i | input | 16 | Per-core request for the core's own rotation slot |
| sec_req_i | input | 16 | Per-core request for a spare slot |
| cfg_we_i | input | 1 | Loads the primary mask, enable mask and mode |
| cfg_pri_i | input | 16 | Primary mask to load (bit i = core i primary) |
| cfg_en_i | input | 16 | Enable mask to load (bit i = core i in rotation) |
| cfg_mode_i | input | 1 | Secondary mode to load: 0 table, 1 scan |
| tbl_we_i | input | 1 | Writes one table entry |
| tbl_addr_i | input | 5 | Table entry address |
| tbl_core_i | input | 4 | Core index stored in the entry |
| tbl_valid_i | input | 1 | Valid bit stored in the entry |
| grant_o | output | 16 | One-hot grant |
| grant_idx_o | output | 4 | Index of the granted core |
| grant_vld_o | output | 1 | A grant is issued this cycle |

## Verification
The bench targets the spare-slot handling that is easy to get wrong. If a design let a primary core's secondary line into the scan, that core would win an extra slot. If a design let a non-primary core's own line win its slot in two-tier mode, it would take slots that belong to the secondary group. The bench also checks the scan's distance-2 tie and the wrap from core 14 to core 1. A wrong tie break, or a scan that did not wrap, would pick a different core. In table mode the bench checks that the pointer holds on an invalid entry and on an entry whose core is not requesting. A design that stepped the pointer on every spare slot would hand later slots to the wrong core. Finally, the bench resets the block after the table has been filled and checks that a stale valid bit produces no grant.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;
  typedef enum logic {
    SEC_TABLE = 1'b0,
    SEC_SCAN  = 1'b1
  } sec_mode_e;
endpackage

// File: rtl/hub_near_scan.sv
// Nearest eligible requester around a start index; NCORE must be a power of two.
module hub_near_scan #(
  parameter int NCORE = 16,
  localparam int IW = $clog2(NCORE)
) (
  input  logic [NCORE-1:0] elig_i,
  input  logic [IW-1:0]    start_i,
  output logic             found_o,
  output logic [IW-1:0]    idx_o
);
  logic [IW-1:0] fwd, bwd;

  // Walk from the farthest distance inward so the last hit is the nearest;
  // the forward probe is evaluated second so it wins ties.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    fwd     = '0;
    bwd     = '0;
    for (int d = NCORE / 2; d >= 0; d--) begin
      bwd = start_i - IW'(d);
      fwd = start_i + IW'(d);
      if (elig_i[bwd]) begin
        found_o = 1'b1;
        idx_o   = bwd;
      end
      if (elig_i[fwd]) begin
        found_o = 1'b1;
        idx_o   = fwd;
      end
    end
  end

  always_comb begin
    if (found_o) begin
      p_scan_hit_eligible_r7 : assert (elig_i[idx_o]);
    end
  end
endmodule

// File: rtl/hub_slot_table.sv
module hub_slot_table #(
  parameter int NCORE = 16,
  parameter int DEPTH = 32,
  localparam int IW = $clog2(NCORE),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [IW-1:0] wcore_i,
  input  logic          wvalid_i,
  input  logic          take_i,
  output logic [IW-1:0] rd_core_o,
  output logic          rd_valid_o
);
  logic [IW-1:0]    core_mem [DEPTH];
  logic [DEPTH-1:0] vld_mem;
  logic [PW-1:0]    ptr_q;

  always_ff @(posedge clk) begin
    if (we_i) core_mem[waddr_i] <= wcore_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_mem <= '0;
      ptr_q   <= '0;
    end else begin
      if (we_i) vld_mem[waddr_i] <= wvalid_i;
      if (take_i) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign rd_core_o  = core_mem[ptr_q];
  assign rd_valid_o = vld_mem[ptr_q];

  // R5: the arbiter may only consume a valid entry
  p_take_valid_r5 : assert property (@(posedge clk) disable iff (rst)
    take_i |-> rd_valid_o);
endmodule

// File: rtl/hub_slot_arb.sv
module hub_slot_arb
  import hub_arb_pkg::*;
#(
  parameter int NCORE = 16,
  parameter int TBL_DEPTH = 32,
  localparam int IW = $clog2(NCORE),
  localparam int PW = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCORE-1:0] own_req_i,
  input  logic [NCORE-1:0] sec_req_i,
  input  logic             cfg_we_i,
  input  logic [NCORE-1:0] cfg_pri_i,
  input  logic [NCORE-1:0] cfg_en_i,
  input  logic             cfg_mode_i,
  input  logic             tbl_we_i,
  input  logic [PW-1:0]    tbl_addr_i,
  input  logic [IW-1:0]    tbl_core_i,
  input  logic             tbl_valid_i,
  output logic [NCORE-1:0] grant_o,
  output logic [IW-1:0]    grant_idx_o,
  output logic             grant_vld_o
);
  logic [IW-1:0]    slot_q;
  logic [NCORE-1:0] pri_q, en_q;
  sec_mode_e        mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      pri_q  <= '0;
      en_q   <= '1;
      mode_q <= SEC_TABLE;
    end else begin
      slot_q <= slot_q + 1'b1;
      if (cfg_we_i) begin
        pri_q  <= cfg_pri_i;
        en_q   <= cfg_en_i;
        mode_q <= sec_mode_e'(cfg_mode_i);
      end
    end
  end

  logic             two_tier, own_hit;
  logic [NCORE-1:0] member, sec_elig;

  assign two_tier = |pri_q;
  assign member   = two_tier ? (en_q & pri_q) : en_q;
  assign own_hit  = member[slot_q] & own_req_i[slot_q];
  assign sec_elig = two_tier ? (sec_req_i & en_q & ~pri_q) : '0;

  logic [IW-1:0] tbl_core;
  logic          tbl_vld, tbl_hit;
  logic [IW-1:0] near_idx;
  logic          near_found, scan_hit;

  assign tbl_hit  = (mode_q == SEC_TABLE) && !own_hit && tbl_vld && sec_elig[tbl_core];
  assign scan_hit = (mode_q == SEC_SCAN) && !own_hit && near_found;

  hub_slot_table #(.NCORE(NCORE), .DEPTH(TBL_DEPTH)) u_table (
    .clk        (clk),
    .rst        (rst),
    .we_i       (tbl_we_i),
    .waddr_i    (tbl_addr_i),
    .wcore_i    (tbl_core_i),
    .wvalid_i   (tbl_valid_i),
    .take_i     (tbl_hit),
    .rd_core_o  (tbl_core),
    .rd_valid_o (tbl_vld)
  );

  hub_near_scan #(.NCORE(NCORE)) u_scan (
    .elig_i  (sec_elig),
    .start_i (slot_q),
    .found_o (near_found),
    .idx_o   (near_idx)
  );

  logic             nxt_vld;
  logic [IW-1:0]    nxt_idx;
  logic [NCORE-1:0] nxt_grant;

  always_comb begin
    nxt_vld = 1'b1;
    nxt_idx = '0;
    if (own_hit)       nxt_idx = slot_q;
    else if (tbl_hit)  nxt_idx = tbl_core;
    else if (scan_hit) nxt_idx = near_idx;
    else               nxt_vld = 1'b0;
    nxt_grant = nxt_vld ? (NCORE'(1) << nxt_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o     <= '0;
      grant_idx_o <= '0;
      grant_vld_o <= 1'b0;
    end else begin
      grant_o     <= nxt_grant;
      grant_idx_o <= nxt_idx;
      grant_vld_o <= nxt_vld;
    end
  end

  // R9: one-hot, index consistent, only to a requester of the previous edge
  p_onehot_r9 : assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  p_idx_match_r9 : assert property (@(posedge clk) disable iff (rst)
    grant_vld_o |-> grant_o[grant_idx_o]);
  p_req_only_r9 : assert property (@(posedge clk) disable iff (rst)
    grant_vld_o |-> (($past(own_req_i | sec_req_i) & grant_o) != '0));
  // R3: disabled cores never receive a grant
  p_disabled_r3 : assert property (@(posedge clk) disable iff (rst)
    grant_vld_o |-> (($past(en_q) & grant_o) != '0));
  // R4: a requesting primary owner always takes its slot
  p_primary_slot_r4 : assert property (@(posedge clk) disable iff (rst)
    (two_tier && pri_q[slot_q] && en_q[slot_q] && own_req_i[slot_q])
      |=> (grant_vld_o && grant_idx_o == $past(slot_q)));
endmodule

// File: tb/sim_hub_slot_arb.sv
`timescale 1ns/1ps
module sim_hub_slot_arb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] own_req = '0, sec_req = '0;
  logic        cfg_we = 1'b0, cfg_mode = 1'b0;
  logic [15:0] cfg_pri = '0, cfg_en = '1;
  logic        tbl_we = 1'b0, tbl_valid = 1'b0;
  logic [4:0]  tbl_addr = '0;
  logic [3:0]  tbl_core = '0;
  logic [15:0] grant;
  logic [3:0]  grant_idx;
  logic        grant_vld;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [3:0] bs;  // slot expected at the next edge: counts from 0 after reset (R2)

  always #5 clk = ~clk;

  always @(posedge clk) bs <= rst ? 4'd0 : bs + 4'd1;

  hub_slot_arb u0 (
    .clk(clk), .rst(rst), .own_req_i(own_req), .sec_req_i(sec_req),
    .cfg_we_i(cfg_we), .cfg_pri_i(cfg_pri), .cfg_en_i(cfg_en), .cfg_mode_i(cfg_mode),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_core_i(tbl_core), .tbl_valid_i(tbl_valid),
    .grant_o(grant), .grant_idx_o(grant_idx), .grant_vld_o(grant_vld)
  );

  typedef struct packed {
    logic [3:0]  slot;
    logic [15:0] own;
    logic [15:0] sec;
    logic        vld;
    logic [3:0]  idx;
  } vec_t;

  // R2 plain round robin vectors
  localparam vec_t VEC [6] = '{
    '{4'd3,  16'h0008, 16'h0000, 1'b1, 4'd3},
    '{4'd5,  16'h0040, 16'hFFFF, 1'b0, 4'd0},
    '{4'd9,  16'hFFFF, 16'h0000, 1'b1, 4'd9},
    '{4'd15, 16'h8000, 16'h0000, 1'b1, 4'd15},
    '{4'd0,  16'h0001, 16'h0000, 1'b1, 4'd0},
    '{4'd1,  16'h0000, 16'hFFFF, 1'b0, 4'd0}
  };

  task automatic check(input logic ev, input logic [3:0] ei, input string tag);
    logic [15:0] eg;
    eg = ev ? (16'h1 << ei) : 16'h0;
    checks++;
    if (grant_vld !== ev || grant !== eg || (ev && grant_idx !== ei)) begin
      fails++;
      $display("FAIL %s: got vld=%0b idx=%0d grant=%h, expected vld=%0b idx=%0d grant=%h",
               tag, grant_vld, grant_idx, grant, ev, ei, eg);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic run(input logic [3:0] s, input logic [15:0] o, input logic [15:0] q,
                     input logic ev, input logic [3:0] ei, input string tag);
    own_req = '0; sec_req = '0;
    while (bs != s) @(negedge clk);
    own_req = o; sec_req = q;
    @(negedge clk);
    own_req = '0; sec_req = '0;
    check(ev, ei, tag);
  endtask

  task automatic cfg(input logic [15:0] p, input logic [15:0] e, input logic m);
    cfg_pri = p; cfg_en = e; cfg_mode = m; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tw(input logic [4:0] a, input logic [3:0] c, input logic v);
    tbl_addr = a; tbl_core = c; tbl_valid = v; tbl_we = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    own_req = '1;
    repeat (3) @(negedge clk);
    check(1'b0, 4'd0, "R1 reset");
    own_req = '0;
    rst = 1'b0;

    for (int i = 0; i < 6; i++)
      run(VEC[i].slot, VEC[i].own, VEC[i].sec, VEC[i].vld, VEC[i].idx, "R2 vector");

    // R10 + R3: config write at slot 3 takes effect for slot 4
    while (bs != 4'd3) @(negedge clk);
    cfg(16'h0000, 16'hFFEF, 1'b0);
    run(4'd4, 16'hFFFF, 16'h0000, 1'b0, 4'd0, "R10 disable next slot");
    run(4'd5, 16'h0020, 16'h0000, 1'b1, 4'd5, "R3 enabled neighbour");
    run(4'd4, 16'h0010, 16'h0000, 1'b0, 4'd0, "R3 disabled core");

    // two-tier, scan mode: cores 2 and 10 primary
    cfg(16'h0404, 16'hFFFF, 1'b1);
    run(4'd2,  16'h0004, 16'hFFFF, 1'b1, 4'd2,  "R4 primary wins");
    run(4'd2,  16'h0000, 16'h0025, 1'b1, 4'd0,  "R8 primary sec masked");
    run(4'd7,  16'h0000, 16'h0220, 1'b1, 4'd9,  "R7 tie forward");
    run(4'd14, 16'h0000, 16'h0002, 1'b1, 4'd1,  "R7 wrap");
    run(4'd7,  16'h0080, 16'h0000, 1'b0, 4'd0,  "R8 non-primary own idle");
    run(4'd3,  16'h0000, 16'h0400, 1'b0, 4'd0,  "R8 primary on sec line");
    cfg(16'h0404, 16'hFDFF, 1'b1);
    run(4'd7,  16'h0000, 16'h0200, 1'b0, 4'd0,  "R3 disabled secondary");

    // table mode
    cfg(16'h0404, 16'hFFFF, 1'b0);
    tw(5'd0, 4'd6, 1'b1);
    tw(5'd1, 4'd3, 1'b1);
    tw(5'd2, 4'd0, 1'b0);
    run(4'd4,  16'h0000, 16'h0048, 1'b1, 4'd6,  "R5 entry0");
    run(4'd5,  16'h0000, 16'h0048, 1'b1, 4'd3,  "R5 entry1");
    run(4'd6,  16'h0000, 16'h0048, 1'b0, 4'd0,  "R6 invalid entry");
    run(4'd8,  16'h0000, 16'h0048, 1'b0, 4'd0,  "R6 pointer held");
    tw(5'd2, 4'd11, 1'b1);
    run(4'd9,  16'h0000, 16'h0040, 1'b0, 4'd0,  "R6 named core idle");
    run(4'd10, 16'h0400, 16'h0800, 1'b1, 4'd10, "R4 primary in table mode");
    run(4'd11, 16'h0000, 16'h0800, 1'b1, 4'd11, "R5 entry2 after hold");
    tw(5'd3, 4'd2, 1'b1);
    run(4'd12, 16'h0000, 16'h0004, 1'b0, 4'd0,  "R8 table names primary");

    // R1: reset clears valid bits and pointer
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cfg(16'h0404, 16'hFFFF, 1'b0);
    run(4'd4, 16'h0000, 16'h0040, 1'b0, 4'd0, "R1 table cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule